// File: doc/BRIEF.md
# Register-Indirect Address Generator

This block turns a six-bit operand selector into a data-memory address and, on the same access, works out the value that goes back into the chosen pointer register. It holds a bank of pointer registers and a bank of matching step registers. The upper three bits of the selector choose how the pointer is used. The lower bits choose which pointer and step pair takes part. A separate space bit picks one of two data memories, and the block passes it to its output.

The address is a combinational function of the selector and the current register contents. Any pointer change that the selected mode calls for is committed at the next rising clock edge, and only when `ea_en` is high. A set of initialisation inputs loads either bank one register at a time. There is no sequencing state. Each cycle, the decoded mode (post-subtract-step, post-add-step, post-decrement, post-increment, plain, indexed, reserved, pre-decrement) is the only control value. The only transition is the register commit at the clock edge.

Top module: `agu_ea_unit`

## Requirements
- R1: After reset every pointer and step register reads zero, so plain mode (selector bits [5:3] = 3'b100) gives address 0 for every register index.
- R2: Mode 3'b000 outputs pointer Rn as the address, then loads Rn with Rn minus step Nn when enabled.
- R3: Mode 3'b001 outputs Rn as the address, then loads Rn with Rn plus Nn when enabled.
- R4: Mode 3'b010 outputs Rn, then decrements it by one. Mode 3'b011 outputs Rn, then increments it by one.
- R5: Mode 3'b100 outputs Rn and leaves it unchanged. Mode 3'b101 outputs Rn plus Nn and leaves Rn unchanged.
- R6: Mode 3'b111 outputs Rn minus one as the address, and Rn holds that value from the next cycle.
- R7: `mem_sel_y` equals `space_in`: 0 selects the X memory, 1 selects the Y memory.
- R8: Mode 3'b110 is reserved. It drives address 0, raises `bad_mode` while `ea_en` is high, and changes no register.
- R9: All pointer arithmetic wraps modulo 2^16.
- R10: When `ea_en` is low, no pointer changes, whatever the mode.
- R11: With `init_we` high, `init_kind` 0 loads pointer `init_idx` and `init_kind` 1 loads step `init_idx`, visible from the next cycle. If a mode update targets the same pointer in the same cycle, the initialisation value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea_field | input | 6 | Mode in bits [5:3], register index in bits [2:0] |
| space_in | input | 1 | Memory space select request |
| ea_en | input | 1 | Access valid; enables the pointer commit |
| init_we | input | 1 | Initialisation write strobe |
| init_kind | input | 1 | 0 = pointer bank, 1 = step bank |
| init_idx | input | 3 | Register index for initialisation |
| init_data | input | 16 | Initialisation value |
| addr_out | output | 16 | Generated memory address |
| mem_sel_y | output | 1 | 1 when the Y memory is addressed |
| bad_mode | output | 1 | Reserved mode requested while enabled |

## Verification
Each mode is run against seeded, non-zero pointer and step values, and the pointer is then read back in plain mode. This separates the address that is used from the value that is committed, and it tells post-update modes apart from the pre-decrement and indexed modes. Pointer values near 0 and 0xFFFF show whether the arithmetic wraps. Runs of disabled accesses and reserved-mode accesses show that the commit is gated. Writing the same pointer through the initialisation port and the mode update in one cycle shows which of the two has priority.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_POST_SUB_N = 3'b000,
        AM_POST_ADD_N = 3'b001,
        AM_POST_DEC   = 3'b010,
        AM_POST_INC   = 3'b011,
        AM_PLAIN      = 3'b100,
        AM_INDEXED    = 3'b101,
        AM_RESERVED   = 3'b110,
        AM_PRE_DEC    = 3'b111
    } am_e;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } op_e;

    typedef struct packed {
        op_e  op;          // arithmetic applied to the pointer
        logic use_step;    // operand is the step register (else one)
        logic addr_is_sum; // address taken from the arithmetic result
        logic writeback;   // result committed into the pointer
        logic illegal;     // reserved encoding
    } am_ctl_t;

endpackage

// File: rtl/agu_mode_decode.sv
module agu_mode_decode
    import agu_pkg::*;
(
    input  logic [MODE_W-1:0] mode_bits,
    output am_ctl_t           ctl
);

    am_e mode;

    always_comb begin
        mode = am_e'(mode_bits);
        ctl  = '{op: OP_PASS, use_step: 1'b0, addr_is_sum: 1'b0,
                 writeback: 1'b0, illegal: 1'b0};
        unique case (mode)
            AM_POST_SUB_N: begin
                ctl.op        = OP_SUB;
                ctl.use_step  = 1'b1;
                ctl.writeback = 1'b1;
            end
            AM_POST_ADD_N: begin
                ctl.op        = OP_ADD;
                ctl.use_step  = 1'b1;
                ctl.writeback = 1'b1;
            end
            AM_POST_DEC: begin
                ctl.op        = OP_SUB;
                ctl.writeback = 1'b1;
            end
            AM_POST_INC: begin
                ctl.op        = OP_ADD;
                ctl.writeback = 1'b1;
            end
            AM_PLAIN: begin
                ctl.op = OP_PASS;
            end
            AM_INDEXED: begin
                ctl.op          = OP_ADD;
                ctl.use_step    = 1'b1;
                ctl.addr_is_sum = 1'b1;
            end
            AM_RESERVED: begin
                ctl.illegal = 1'b1;
            end
            AM_PRE_DEC: begin
                ctl.op          = OP_SUB;
                ctl.addr_is_sum = 1'b1;
                ctl.writeback   = 1'b1;
            end
            default: begin
                ctl.illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/agu_arith.sv
module agu_arith
    import agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  am_ctl_t       ctl,
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] next_ptr
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] operand;
    logic [AW-1:0] result;

    always_comb begin
        operand = ctl.use_step ? step : ONE;
        unique case (ctl.op)
            OP_ADD:  result = ptr + operand;
            OP_SUB:  result = ptr - operand;
            default: result = ptr;
        endcase
    end

    always_comb begin
        next_ptr = result;
        if (ctl.illegal)
            addr = '0;
        else if (ctl.addr_is_sum)
            addr = result;
        else
            addr = ptr;
    end

endmodule

// File: rtl/agu_regfile.sv
module agu_regfile #(
    parameter int AW   = 16,
    parameter int NREG = 8,
    parameter int IW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] ptr_rd,
    output logic [AW-1:0] step_rd,
    input  logic          upd_we,
    input  logic [IW-1:0] upd_idx,
    input  logic [AW-1:0] upd_data,
    input  logic          ini_we,
    input  logic          ini_kind,
    input  logic [IW-1:0] ini_idx,
    input  logic [AW-1:0] ini_data
);

    logic [AW-1:0] ptr_q  [NREG];
    logic [AW-1:0] step_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic ini_hit_ptr;
        logic ini_hit_step;
        logic upd_hit;

        assign ini_hit_ptr  = ini_we && !ini_kind && (ini_idx == IW'(g));
        assign ini_hit_step = ini_we &&  ini_kind && (ini_idx == IW'(g));
        assign upd_hit      = upd_we && (upd_idx == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q[g] <= '0;
            end else if (ini_hit_ptr) begin
                ptr_q[g] <= ini_data;
            end else if (upd_hit) begin
                ptr_q[g] <= upd_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                step_q[g] <= '0;
            end else if (ini_hit_step) begin
                step_q[g] <= ini_data;
            end
        end
    end

    assign ptr_rd  = ptr_q[rd_idx];
    assign step_rd = step_q[rd_idx];

endmodule

// File: rtl/agu_ea_unit.sv
module agu_ea_unit
    import agu_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [MODE_W+$clog2(NUM_REGS)-1:0] ea_field,
    input  logic                         space_in,
    input  logic                         ea_en,
    input  logic                         init_we,
    input  logic                         init_kind,
    input  logic [$clog2(NUM_REGS)-1:0]  init_idx,
    input  logic [ADDR_W-1:0]            init_data,
    output logic [ADDR_W-1:0]            addr_out,
    output logic                         mem_sel_y,
    output logic                         bad_mode
);

    localparam int IDX_W = $clog2(NUM_REGS);

    logic [IDX_W-1:0]  sel_idx;
    logic [MODE_W-1:0] sel_mode;
    am_ctl_t           ctl;
    logic [ADDR_W-1:0] ptr_val;
    logic [ADDR_W-1:0] step_val;
    logic [ADDR_W-1:0] next_ptr;
    logic [ADDR_W-1:0] addr_c;
    logic              commit;

    assign sel_idx  = ea_field[IDX_W-1:0];
    assign sel_mode = ea_field[MODE_W+IDX_W-1:IDX_W];

    agu_mode_decode u_dec (
        .mode_bits (sel_mode),
        .ctl       (ctl)
    );

    agu_regfile #(
        .AW   (ADDR_W),
        .NREG (NUM_REGS),
        .IW   (IDX_W)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (sel_idx),
        .ptr_rd   (ptr_val),
        .step_rd  (step_val),
        .upd_we   (commit),
        .upd_idx  (sel_idx),
        .upd_data (next_ptr),
        .ini_we   (init_we),
        .ini_kind (init_kind),
        .ini_idx  (init_idx),
        .ini_data (init_data)
    );

    agu_arith #(
        .AW (ADDR_W)
    ) u_alu (
        .ctl      (ctl),
        .ptr      (ptr_val),
        .step     (step_val),
        .addr     (addr_c),
        .next_ptr (next_ptr)
    );

    assign commit = ea_en && ctl.writeback && !ctl.illegal;

    always_comb begin
        addr_out  = addr_c;
        mem_sel_y = space_in;
        bad_mode  = ea_en && ctl.illegal;
    end

endmodule

// File: rtl/agu_ea_chk.sv
module agu_ea_chk #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W+2:0]  ea_field,
    input logic              ea_en,
    input logic              init_we,
    input logic [ADDR_W-1:0] addr_out,
    input logic              bad_mode
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [2:0] mode_b;
    assign mode_b = ea_field[IDX_W+2:IDX_W];

    // R8
    r8_bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mode |-> (addr_out == '0));

    // R8
    r8_bad_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ea_en |-> !bad_mode);

    // R4
    r4_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_en && !init_we && mode_b == 3'b011) |=>
        ((ea_field != {3'b100, $past(ea_field[IDX_W-1:0])}) ||
         (addr_out == $past(addr_out) + ONE)));

    // R4
    r4_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_en && !init_we && mode_b == 3'b010) |=>
        ((ea_field != {3'b100, $past(ea_field[IDX_W-1:0])}) ||
         (addr_out == $past(addr_out) - ONE)));

    // R6
    r6_pre_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_en && !init_we && mode_b == 3'b111) |=>
        ((ea_field != {3'b100, $past(ea_field[IDX_W-1:0])}) ||
         (addr_out == $past(addr_out))));

    // R5
    r5_plain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_en && !init_we && mode_b == 3'b100) |=>
        ((ea_field != $past(ea_field)) || $stable(addr_out)));

    // R10
    r10_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ea_en && !init_we) |=>
        ((ea_field != $past(ea_field)) || $stable(addr_out)));

endmodule

bind agu_ea_unit agu_ea_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ea_field (ea_field),
    .ea_en    (ea_en),
    .init_we  (init_we),
    .addr_out (addr_out),
    .bad_mode (bad_mode)
);

// File: tb/agu_ea_unit_test.sv
`timescale 1ns/1ps
module agu_ea_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ea_field = '0;
    logic        space_in = 1'b0;
    logic        ea_en = 1'b0;
    logic        init_we = 1'b0;
    logic        init_kind = 1'b0;
    logic [2:0]  init_idx = '0;
    logic [15:0] init_data = '0;
    logic [15:0] addr_out;
    logic        mem_sel_y;
    logic        bad_mode;

    always #2.5 clk = ~clk;

    agu_ea_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ea_field  (ea_field),
        .space_in  (space_in),
        .ea_en     (ea_en),
        .init_we   (init_we),
        .init_kind (init_kind),
        .init_idx  (init_idx),
        .init_data (init_data),
        .addr_out  (addr_out),
        .mem_sel_y (mem_sel_y),
        .bad_mode  (bad_mode)
    );

    typedef struct {
        logic [15:0] addr;
        logic        sel;
        logic        bad;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] mptr [8];
    logic [15:0] mstep[8];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    // Driver: applies one cycle of stimulus, predicts outputs, updates model.
    task automatic step(input logic [2:0] mode, input logic [2:0] idx,
                        input logic sp, input logic en,
                        input logic iwe, input logic ikind,
                        input logic [2:0] iidx, input logic [15:0] idata,
                        input string tag);
        exp_t        e;
        logic [15:0] r;
        logic [15:0] n;
        logic [15:0] nr;
        logic        wb;
        @(negedge clk);
        ea_field  = {mode, idx};
        space_in  = sp;
        ea_en     = en;
        init_we   = iwe;
        init_kind = ikind;
        init_idx  = iidx;
        init_data = idata;
        r  = mptr[idx];
        n  = mstep[idx];
        nr = r;
        wb = 1'b0;
        e.bad = 1'b0;
        case (mode)
            3'b000: begin e.addr = r;         nr = r - n;     wb = 1'b1; end
            3'b001: begin e.addr = r;         nr = r + n;     wb = 1'b1; end
            3'b010: begin e.addr = r;         nr = r - 16'd1; wb = 1'b1; end
            3'b011: begin e.addr = r;         nr = r + 16'd1; wb = 1'b1; end
            3'b100: begin e.addr = r; end
            3'b101: begin e.addr = r + n; end
            3'b110: begin e.addr = 16'd0; e.bad = en; end
            default: begin e.addr = r - 16'd1; nr = r - 16'd1; wb = 1'b1; end
        endcase
        e.sel = sp;
        e.tag = tag;
        sb.push_back(e);
        if (en && wb) mptr[idx] = nr;
        if (iwe) begin
            if (ikind) mstep[iidx] = idata;
            else       mptr[iidx]  = idata;
        end
    endtask

    task automatic load(input logic kind, input logic [2:0] idx,
                        input logic [15:0] val);
        step(3'b100, idx, 1'b0, 1'b0, 1'b1, kind, idx, val, "R11");
    endtask

    task automatic peek(input logic [2:0] idx, input string tag);
        step(3'b100, idx, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, tag);
    endtask

    // Monitor: compares each cycle's outputs with the queued prediction.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (addr_out !== e.addr || mem_sel_y !== e.sel ||
                    bad_mode !== e.bad) begin
                    errors++;
                    $display("FAIL %s: addr=%h sel=%b bad=%b expected addr=%h sel=%b bad=%b",
                             e.tag, addr_out, mem_sel_y, bad_mode,
                             e.addr, e.sel, e.bad);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            mptr[i]  = 16'd0;
            mstep[i] = 16'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values through plain mode
        for (int i = 0; i < 8; i++) peek(3'(i), "R1");

        // R7: space select both ways
        step(3'b100, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R7");
        step(3'b100, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R7");

        // R11: seed registers
        load(1'b0, 3'd1, 16'h1000); load(1'b1, 3'd1, 16'h0020);
        load(1'b0, 3'd2, 16'h0005); load(1'b1, 3'd2, 16'h0010);
        load(1'b0, 3'd3, 16'hFFFF);
        load(1'b0, 3'd4, 16'h0000);
        load(1'b0, 3'd5, 16'h4000); load(1'b1, 3'd5, 16'hC100);
        load(1'b0, 3'd6, 16'h0001);
        load(1'b0, 3'd7, 16'h0700);
        load(1'b1, 3'd0, 16'h0033);

        // R3: post-add step
        step(3'b001, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R3");
        step(3'b001, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R3");
        peek(3'd1, "R3");

        // R2 / R9: post-subtract step wrapping below zero
        step(3'b000, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R2");
        peek(3'd2, "R9");

        // R4 / R9: increment across 0xFFFF, decrement across zero
        step(3'b011, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R4");
        peek(3'd3, "R9");
        step(3'b010, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R4");
        peek(3'd4, "R9");

        // R5: indexed without update (sum wraps), then plain
        step(3'b101, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R5");
        step(3'b101, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R5");
        peek(3'd5, "R5");

        // R6: pre-decrement twice, crossing zero on the second
        step(3'b111, 3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R6");
        step(3'b111, 3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R6");
        peek(3'd6, "R6");

        // R8: reserved mode, enabled and disabled, no register change
        step(3'b110, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R8");
        step(3'b110, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 16'd0, "R8");
        peek(3'd7, "R8");

        // R10: disabled update modes leave pointers alone
        step(3'b011, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 16'd0, "R10");
        step(3'b000, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 16'd0, "R10");
        step(3'b111, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 16'd0, "R10");
        peek(3'd7, "R10");
        peek(3'd1, "R10");
        peek(3'd6, "R10");

        // R11: init write beats a same-cycle update on the same pointer
        step(3'b011, 3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 3'd7, 16'hABCD, "R11");
        peek(3'd7, "R11");
        // R11: step-bank write seen by indexed mode
        step(3'b101, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 16'h0100, "R11");
        step(3'b101, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 16'd0, "R11");

        @(negedge clk);
        ea_en   = 1'b0;
        init_we = 1'b0;
        wait (sb.size() == 0);
        #2;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule